// File: doc/BRIEF.md
# Prescaled Multi-Channel Trigger Rate Counter

The block measures trigger rates on five lines at once: four patch trigger inputs and one combined trigger input. Each line feeds its own saturating event counter. All five counters start, run and clear together over one gate period. The gate length is set by an 8-bit prescale value `y` and equals `(y+1)` half-second ticks. A clock divider derives the half-second tick from the system clock.

When a gate period runs to its end without interruption, the block latches all five counts and a packed overflow byte into output registers. It then raises a single-cycle valid strobe, and the counters begin the next period from zero. A settings-change pulse restarts the tick divider, the period timer and every counter. The partial counts are dropped and no result is published for the interrupted period.

The trigger inputs are expected to be synchronous to `clk_i`. The prescale input must be held steady while a period runs, and any change to it is accompanied by a settings-change pulse.

Top module: `trig_rate_counter`

## Requirements
- R1: While and after reset, and before the first period completes, `counts_o`, `ovf_flags_o` and `result_valid_o` are all zero.
- R2: Each rising edge of a trigger input (high in this cycle, low in the previous cycle) adds exactly one event. An input held high for many cycles counts once.
- R3: Counting from the cycle after a settings-change pulse, a period lasts exactly `(y+1)*TICK_DIV` cycles, where `y` is `prescale_i`. `result_valid_o` is high for one cycle only, directly after the last cycle of the period, and is never high earlier.
- R4: With the strobe, `counts_o[c*CNT_W +: CNT_W]` holds the event count of channel `c` for the finished period. Channels 0 to 3 are the patch inputs `patch_trig_i[0..3]` and channel 4 is `comb_trig_i`. An edge in the final cycle of the period counts toward that period.
- R5: Without a settings change, periods follow back to back. The counters start the next period from zero, so the next strobe comes `(y+1)*TICK_DIV` cycles later and carries only that period's events.
- R6: A channel that sees more than `2^CNT_W-1` events reports `2^CNT_W-1` and sets its overflow flag. A channel that sees exactly `2^CNT_W-1` events reports that value with its flag clear.
- R7: In `ovf_flags_o`, bit `c` is the overflow flag of channel `c`: bit 0 is patch A, bits 1 to 3 are patches B to D, and bit 4 is the combined trigger. Bits 7 to 5 are always zero.
- R8: A settings-change pulse discards the partial counts of all channels together, including any edge in the pulse cycle. No strobe is raised for the interrupted period, and a fresh full period begins.
- R9: `counts_o` and `ovf_flags_o` change only together with the strobe and hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| patch_trig_i | input | 4 | Synchronous patch trigger lines, channels 0 to 3 |
| comb_trig_i | input | 1 | Synchronous combined trigger line, channel 4 |
| prescale_i | input | PRE_W (8) | Gate length selector `y`; period is `(y+1)` half-second ticks |
| settings_change_i | input | 1 | Pulse that restarts the timer and all counters |
| counts_o | output | 5*CNT_W (80) | Latched counts, channel `c` at `[c*CNT_W +: CNT_W]` |
| ovf_flags_o | output | 8 | Latched overflow flags, bit `c` for channel `c` |
| result_valid_o | output | 1 | One-cycle strobe when new results are latched |

## Verification
The bench shrinks the tick divider to 16 cycles and the counters to 5 bits. It then sweeps several prescale values with pulse trains of different lengths per channel. These tell apart a correct period length from an off-by-one in the tick or half-tick count, and a missed last-cycle edge from a correct one. A held-high input separates edge counting from level counting. Event totals of 31, 32 and 64 separate saturation from wrapping and locate each overflow flag bit. A back-to-back empty period and a restart in the middle of a pulse train tell whether leftover counts leak into a later result.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int unsigned NUM_PATCH = 4;
  localparam int unsigned NUM_CH    = NUM_PATCH + 1;
  localparam int unsigned FLAG_W    = 8;

  typedef enum logic [2:0] {
    CH_A   = 3'd0,
    CH_B   = 3'd1,
    CH_C   = 3'd2,
    CH_D   = 3'd3,
    CH_SUM = 3'd4
  } ch_e;
endpackage

// File: rtl/trc_tick_div.sv
module trc_tick_div #(
  parameter int unsigned DIV = 25_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (restart_i || cnt_q == LAST)  cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST) && !restart_i;

  // ticks are at least two cycles apart for DIV >= 2
  assert_tick_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o)
    else $error("tick repeated on consecutive cycles");
endmodule

// File: rtl/trc_gate_timer.sv
module trc_gate_timer #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [PRE_W-1:0] limit_i,
  output logic             done_o
);
  logic [PRE_W-1:0] hc_q;

  // >= keeps a lowered limit from wrapping the half-tick count
  assign done_o = tick_i && (hc_q >= limit_i) && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  hc_q <= '0;
    else if (restart_i || done_o) hc_q <= '0;
    else if (tick_i)              hc_q <= hc_q + 1'b1;
  end

  assert_no_done_after_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !done_o)
    else $error("period end right after restart");
endmodule

// File: rtl/trc_event_cnt.sv
module trc_event_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             restart_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_nx_o,
  output logic             ovf_nx_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  logic             prev_q;
  logic             edge_w;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= trig_i;
  end

  assign edge_w = trig_i && !prev_q;

  always_comb begin
    cnt_nx_o = cnt_q;
    ovf_nx_o = ovf_q;
    if (edge_w) begin
      if (cnt_q == MAX) ovf_nx_o = 1'b1;
      else              cnt_nx_o = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (restart_i || clear_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nx_o;
      ovf_q <= ovf_nx_o;
    end
  end

  assert_sat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> cnt_q == MAX)
    else $error("overflow without saturation");

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !clear_i) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1))
    else $error("counter moved by more than one");

  assert_restart_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0 && !ovf_q))
    else $error("partial count survived restart");
endmodule

// File: rtl/trig_rate_counter.sv
module trig_rate_counter
  import trc_pkg::*;
#(
  parameter int unsigned TICK_DIV = 25_000_000,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PRE_W    = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_PATCH-1:0]    patch_trig_i,
  input  logic                    comb_trig_i,
  input  logic [PRE_W-1:0]        prescale_i,
  input  logic                    settings_change_i,
  output logic [NUM_CH*CNT_W-1:0] counts_o,
  output logic [FLAG_W-1:0]       ovf_flags_o,
  output logic                    result_valid_o
);
  localparam int unsigned OUT_W = NUM_CH * CNT_W;
  localparam int unsigned PAD_W = FLAG_W - NUM_CH;

  logic              tick_w;
  logic              done_w;
  logic [NUM_CH-1:0] trig_vec;
  logic [CNT_W-1:0]  cnt_nx [NUM_CH];
  logic [NUM_CH-1:0] ovf_nx;
  logic [OUT_W-1:0]  counts_d;
  logic [OUT_W-1:0]  counts_q;
  logic [FLAG_W-1:0] flags_q;
  logic              valid_q;

  assign trig_vec = {comb_trig_i, patch_trig_i};

  trc_tick_div #(.DIV(TICK_DIV)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (settings_change_i),
    .tick_o    (tick_w)
  );

  trc_gate_timer #(.PRE_W(PRE_W)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (settings_change_i),
    .tick_i    (tick_w),
    .limit_i   (prescale_i),
    .done_o    (done_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    trc_event_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .trig_i    (trig_vec[g]),
      .restart_i (settings_change_i),
      .clear_i   (done_w),
      .cnt_nx_o  (cnt_nx[g]),
      .ovf_nx_o  (ovf_nx[g])
    );
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) counts_d[c*CNT_W +: CNT_W] = cnt_nx[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      counts_q <= '0;
      flags_q  <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= done_w;
      if (done_w) begin
        counts_q <= counts_d;
        flags_q  <= {{PAD_W{1'b0}}, ovf_nx};
      end
    end
  end

  assign counts_o       = counts_q;
  assign ovf_flags_o    = flags_q;
  assign result_valid_o = valid_q;

  assert_one_cycle_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o)
    else $error("valid strobe longer than one cycle");

  assert_no_valid_after_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settings_change_i |=> !result_valid_o)
    else $error("result published for interrupted period");

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(counts_o) || !$stable(ovf_flags_o)) |-> result_valid_o)
    else $error("results changed without strobe");

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    assert_flag_sat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_flags_o[g] |-> counts_o[g*CNT_W +: CNT_W] == {CNT_W{1'b1}})
      else $error("flag set without saturated count");
  end
endmodule

// File: tb/sim_trig_rate_counter.sv
module sim_trig_rate_counter;
  localparam int DIV = 16;
  localparam int CW  = 5;
  localparam int MAXV = (1 << CW) - 1;
  localparam int HELD = 255;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [4:0]    tv = '0;
  logic [7:0]    prescale = '0;
  logic          settings = 1'b0;
  logic [5*CW-1:0] counts;
  logic [7:0]    flags;
  logic          valid;

  int n_checks = 0;
  int n_fail = 0;
  int pat[5];

  always #10 clk = ~clk;

  trig_rate_counter #(.TICK_DIV(DIV), .CNT_W(CW), .PRE_W(8)) u0 (
    .clk_i             (clk),
    .rst_ni            (rst_ni),
    .patch_trig_i      (tv[3:0]),
    .comb_trig_i       (tv[4]),
    .prescale_i        (prescale),
    .settings_change_i (settings),
    .counts_o          (counts),
    .ovf_flags_o       (flags),
    .result_valid_o    (valid)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int edges_of(int p);
    return (p == HELD) ? 1 : p;
  endfunction

  function automatic logic [4:0] drive_at(int i);
    logic [4:0] v;
    for (int c = 0; c < 5; c++)
      v[c] = (pat[c] == HELD) || ((i % 2 == 1) && (i / 2 < pat[c]));
    return v;
  endfunction

  task automatic check_results(string req, bit zero);
    int exp_flags = 0;
    for (int c = 0; c < 5; c++) begin
      int e = zero ? 0 : edges_of(pat[c]);
      chk(req, $sformatf("count ch%0d", c), counts[c*CW +: CW], (e > MAXV) ? MAXV : e);
      if (e > MAXV) exp_flags |= (1 << c);
    end
    chk("R7", "overflow byte", flags, exp_flags);
  endtask

  // restart, run one full period with pattern pat, check strobe and results
  task automatic run_period(int y);
    int p = (y + 1) * DIV;
    bit early = 0;
    @(negedge clk);
    settings = 1'b1; prescale = 8'(y); tv = '0;
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      settings = 1'b0;
      if (valid) early = 1;
      tv = drive_at(i);
    end
    @(negedge clk);
    tv = '0;
    chk("R3", "no early strobe", early, 0);
    chk("R3", "strobe after period", valid, 1);
    check_results("R4", 0);
    @(negedge clk);
    chk("R3", "strobe one cycle", valid, 0);
  endtask

  // follow-on period with no input; called right after run_period
  task automatic next_empty(int y);
    int p = (y + 1) * DIV;
    bit early = 0;
    for (int k = 2; k < p; k++) begin
      @(negedge clk);
      if (valid) early = 1;
      if (k == p / 2) check_results("R9", 0);
    end
    @(negedge clk);
    chk("R5", "no early strobe", early, 0);
    chk("R5", "back-to-back strobe", valid, 1);
    check_results("R5", 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", valid, 0);
    chk("R1", "counts in reset", counts, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "valid after reset", valid, 0);
    chk("R1", "flags after reset", flags, 0);

    // short period, mixed pulse counts (R2, R4)
    pat = '{1, 2, 3, 8, 0};
    run_period(0);

    // held-high line counts once; pulse in last cycle counted (R2, R4)
    pat = '{HELD, 0, 5, 16, 7};
    run_period(1);
    next_empty(1);

    // saturation boundaries (R6): 64 and 32 overflow, 31 does not
    pat = '{64, 31, 0, 5, 32};
    run_period(7);
    next_empty(7);

    // flag bit positions (R7)
    pat = '{0, 0, 32, 0, 0};
    run_period(3);
    pat = '{0, 32, 0, 32, 0};
    run_period(3);

    // interrupted period: partial counts discarded (R8)
    begin
      bit early = 0;
      @(negedge clk);
      settings = 1'b1; prescale = 8'd3; tv = '0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        settings = 1'b0;
        if (valid) early = 1;
        tv = (i % 2 == 1) ? 5'h1f : 5'h00;
      end
      chk("R8", "no strobe before restart", early, 0);
    end
    pat = '{2, 0, 1, 0, 3};
    run_period(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule